// File: doc/BRIEF.md
# Configurable Scan Chain Driver Network

This block fans a narrow input slice out to a wider set of scan chains. Every clock cycle in which the slice is marked valid, each of the M chains receives one bit, and all of those bits are captured together into a registered output. Each chain's bit comes from a per-chain route. The route is one of four things: a plain copy of one slice bit, the inverse of one slice bit, a two-input logic function of two slice bits, or a constant zero.

Because several chains can share, invert or combine the same slice columns, M can be larger than the slice width N. Padding bits for chains shorter than the longest chain are ordinary slice content, so all chains load in the same number of cycles.

Routes are loaded through a small write port, with one configuration word per chain. A write is refused while the chains are shifting, so the mapping cannot change in the middle of a burst of slices. A two-state controller tracks the burst. In ST_IDLE, configuration writes are accepted. In ST_SHIFT, `scan_en` is high and writes are refused. The transition T_START goes from ST_IDLE to ST_SHIFT when the slice is valid. T_STAY holds ST_SHIFT while the slice stays valid. T_STOP goes from ST_SHIFT back to ST_IDLE when the slice is not valid.

Top module: `scan_chain_driver`

## Requirements
- R1: After reset, `scan_en` is 0 and `scan_data` is all zeros. Chain j copies slice bit (j mod N).
- R2: The configuration word is {func[2:0], src_b, src_a, mode[1:0]}, with SW-bit source indices. Mode 0 drives the chain with `slice_in[src_a]`.
- R3: Mode 1 drives the chain with the inverse of `slice_in[src_a]`.
- R4: Mode 2 drives the chain with f(`slice_in[src_a]`, `slice_in[src_b]`). The func codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR and 5 XNOR.
- R5: `scan_data` takes the new chain bits one cycle after the clock edge at which `slice_vld` is sampled high. When `slice_vld` is low at an edge, `scan_data` holds its value.
- R6: `scan_en` equals the value `slice_vld` had at the previous clock edge.
- R7: A configuration write presented while `scan_en` is 1 is ignored.
- R8: A configuration write whose `cfg_addr` is M or higher is ignored.
- R9: Mode 3, and mode 2 with func code 6 or 7, drive the chain with 0.
- R10: If a write and a valid slice arrive at the same edge while `scan_en` is 0, the write takes effect. That slice is mapped with the configuration that was in place before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slice_in | input | N | Input slice |
| slice_vld | input | 1 | Slice valid strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Chain index for the write |
| cfg_wdata | input | CW | Configuration word |
| scan_data | output | M | Registered bits into the M chains |
| scan_en | output | 1 | Shift enable to the chains, aligned with scan_data |

## Verification
Several cases are hard to reach from the ports.

A refused write can only be seen later, through the slices that follow it. The stimulus therefore writes an inverting route into a chain in the middle of a valid burst, and then keeps shifting so the unchanged copy route shows on `scan_data`.

The same-edge case in R10 is reached by raising the first valid slice of a burst together with a write. The bench then checks that the old route maps that slice and the new route maps the next one.

The unused addresses in R8 exist only because the default M is not a power of two. The bench writes to those addresses and confirms that no chain changes.

// File: rtl/scan_drv_pkg.sv
package scan_drv_pkg;

    localparam int MODE_W = 2;
    localparam int FN_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_COPY = 2'd0,
        MD_INV  = 2'd1,
        MD_PAIR = 2'd2,
        MD_ZERO = 2'd3
    } drv_mode_e;

    typedef enum logic [FN_W-1:0] {
        FN_AND  = 3'd0,
        FN_NAND = 3'd1,
        FN_OR   = 3'd2,
        FN_NOR  = 3'd3,
        FN_XOR  = 3'd4,
        FN_XNOR = 3'd5,
        FN_RSV6 = 3'd6,
        FN_RSV7 = 3'd7
    } pair_fn_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } drv_state_e;

endpackage

// File: rtl/scan_cfg_bank.sv
module scan_cfg_bank
    import scan_drv_pkg::*;
#(
    parameter int N  = 4,
    parameter int M  = 6,
    parameter int SW = 2,
    parameter int AW = 3,
    parameter int CW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_busy,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [CW-1:0]   cfg_wdata,
    output logic [M*CW-1:0] cfg_flat
);

    for (genvar j = 0; j < M; j++) begin : g_word
        // Reset route: plain copy of slice bit (j mod N)
        localparam logic [CW-1:0] DEF_WORD =
            CW'({SW'(0), SW'(j % N), MD_COPY});

        logic sel;
        assign sel = cfg_we && !shift_busy && (cfg_addr == AW'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_flat[j*CW +: CW] <= DEF_WORD;
            end else if (sel) begin
                cfg_flat[j*CW +: CW] <= cfg_wdata;
            end
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_busy |=> $stable(cfg_flat)); // R7

    AST_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_addr) >= M)) |=> $stable(cfg_flat)); // R8

endmodule

// File: rtl/scan_chain_eval.sv
module scan_chain_eval
    import scan_drv_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 2,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  slice,
    input  logic [CW-1:0] cfg_word,
    output logic          chain_bit
);

    localparam int PW = 1 << SW;

    logic [PW-1:0] slice_ext;
    logic [SW-1:0] src_a;
    logic [SW-1:0] src_b;
    drv_mode_e     mode;
    pair_fn_e      fn;
    logic          a_bit;
    logic          b_bit;
    logic          pair_bit;

    // Source indices at or above N read as zero
    assign slice_ext = PW'(slice);
    assign mode      = drv_mode_e'(cfg_word[MODE_W-1:0]);
    assign src_a     = cfg_word[MODE_W +: SW];
    assign src_b     = cfg_word[MODE_W+SW +: SW];
    assign fn        = pair_fn_e'(cfg_word[CW-1 -: FN_W]);
    assign a_bit     = slice_ext[src_a];
    assign b_bit     = slice_ext[src_b];

    always_comb begin
        unique case (fn)
            FN_AND:  pair_bit = a_bit & b_bit;
            FN_NAND: pair_bit = ~(a_bit & b_bit);
            FN_OR:   pair_bit = a_bit | b_bit;
            FN_NOR:  pair_bit = ~(a_bit | b_bit);
            FN_XOR:  pair_bit = a_bit ^ b_bit;
            FN_XNOR: pair_bit = ~(a_bit ^ b_bit);
            default: pair_bit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_COPY: chain_bit = a_bit;
            MD_INV:  chain_bit = ~a_bit;
            MD_PAIR: chain_bit = pair_bit;
            default: chain_bit = 1'b0;
        endcase
    end

    AST_ZERO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ZERO) |-> !chain_bit); // R9

    AST_RSV_FN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PAIR && (fn == FN_RSV6 || fn == FN_RSV7)) |-> !chain_bit); // R9

endmodule

// File: rtl/scan_shift_ctrl.sv
module scan_shift_ctrl
    import scan_drv_pkg::*;
#(
    parameter int M = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slice_vld,
    input  logic [M-1:0] next_bits,
    output logic [M-1:0] scan_data,
    output logic         scan_en
);

    drv_state_e state_q;
    drv_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions T_START, T_STAY and T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (slice_vld)  state_d = ST_SHIFT;
            ST_SHIFT: if (!slice_vld) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs: data register loads only on a valid slice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_data <= '0;
        end else if (slice_vld) begin
            scan_data <= next_bits;
        end
    end

    assign scan_en = (state_q == ST_SHIFT);

    AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        slice_vld |=> scan_en); // R6

    AST_EN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_vld |=> !scan_en); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_vld |=> $stable(scan_data)); // R5

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        slice_vld |=> (scan_data == $past(next_bits))); // R5

endmodule

// File: rtl/scan_chain_driver.sv
module scan_chain_driver
    import scan_drv_pkg::*;
#(
    parameter int  N  = 4,
    parameter int  M  = 6,
    localparam int SW = (N > 1) ? $clog2(N) : 1,
    localparam int AW = (M > 1) ? $clog2(M) : 1,
    localparam int CW = MODE_W + 2 * SW + FN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  slice_in,
    input  logic          slice_vld,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic [M-1:0]  scan_data,
    output logic          scan_en
);

    logic [M*CW-1:0] cfg_flat;
    logic [M-1:0]    next_bits;

    scan_cfg_bank #(
        .N (N),
        .M (M),
        .SW(SW),
        .AW(AW),
        .CW(CW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_busy(scan_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_flat  (cfg_flat)
    );

    for (genvar j = 0; j < M; j++) begin : g_chain
        scan_chain_eval #(
            .N (N),
            .SW(SW),
            .CW(CW)
        ) u_eval (
            .clk      (clk),
            .rst_n    (rst_n),
            .slice    (slice_in),
            .cfg_word (cfg_flat[j*CW +: CW]),
            .chain_bit(next_bits[j])
        );
    end

    scan_shift_ctrl #(
        .M(M)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .slice_vld(slice_vld),
        .next_bits(next_bits),
        .scan_data(scan_data),
        .scan_en  (scan_en)
    );

endmodule

// File: tb/scan_chain_driver_tb.sv
module scan_chain_driver_tb;

    localparam int N  = 4;
    localparam int M  = 6;
    localparam int SW = 2;
    localparam int AW = 3;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  slice_in = '0;
    logic          slice_vld = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [M-1:0]  scan_data;
    logic          scan_en;

    always #5 clk = ~clk;

    scan_chain_driver #(.N(N), .M(M)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .slice_in (slice_in),
        .slice_vld(slice_vld),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .scan_data(scan_data),
        .scan_en  (scan_en)
    );

    // Behavioural reference state
    int          md_q[M];
    int          sa_q[M];
    int          sb_q[M];
    int          fn_q[M];
    logic [M-1:0] exp_data;
    logic         exp_en;
    string        cur_tag;
    int           n_cmp = 0;
    int           n_bad = 0;
    int           cyc = 0;

    function automatic logic ref_bit(int md, int a, int b, int fn, logic [N-1:0] s);
        logic x;
        logic y;
        x = (a < N) ? s[a] : 1'b0;
        y = (b < N) ? s[b] : 1'b0;
        case (md)
            0: return x;
            1: return !x;
            2: case (fn)
                   0: return x & y;
                   1: return !(x & y);
                   2: return x | y;
                   3: return !(x | y);
                   4: return x ^ y;
                   5: return !(x ^ y);
                   default: return 1'b0;
               endcase
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare();
        n_cmp++;
        if (scan_data !== exp_data) begin
            n_bad++;
            $display("FAIL %s scan_data actual=%b expected=%b", cur_tag, scan_data, exp_data);
        end
        n_cmp++;
        if (scan_en !== exp_en) begin
            n_bad++;
            $display("FAIL %s scan_en actual=%b expected=%b", cur_tag, scan_en, exp_en);
        end
    endtask

    task automatic step(input logic vld, input logic [N-1:0] sl, input logic we,
                        input logic [AW-1:0] ad, input logic [CW-1:0] wd, input string tg);
        logic busy;
        @(negedge clk);
        compare();
        slice_vld = vld;
        slice_in  = sl;
        cfg_we    = we;
        cfg_addr  = ad;
        cfg_wdata = wd;
        busy = exp_en;
        if (vld) begin
            for (int j = 0; j < M; j++)
                exp_data[j] = ref_bit(md_q[j], sa_q[j], sb_q[j], fn_q[j], sl);
        end
        if (we && !busy && int'(ad) < M) begin
            md_q[ad] = int'(wd[1:0]);
            sa_q[ad] = int'(wd[3:2]);
            sb_q[ad] = int'(wd[5:4]);
            fn_q[ad] = int'(wd[8:6]);
        end
        exp_en  = vld;
        cur_tag = tg;
    endtask

    function automatic logic [CW-1:0] enc(int md, int a, int b, int fn);
        return {3'(fn), 2'(b), 2'(a), 2'(md)};
    endfunction

    task automatic cfg_write(int ad, int md, int a, int b, int fn, string tg);
        step(1'b0, N'($urandom), 1'b1, AW'(ad), enc(md, a, b, fn), tg);
    endtask

    task automatic slices(int cnt, string tg);
        for (int i = 0; i < cnt; i++)
            step(1'b1, N'($urandom), 1'b0, '0, '0, tg);
    endtask

    task automatic idle(string tg);
        step(1'b0, N'($urandom), 1'b0, '0, '0, tg);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=<50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < M; j++) begin
            md_q[j] = 0; sa_q[j] = j % N; sb_q[j] = 0; fn_q[j] = 0;
        end
        exp_data = '0;
        exp_en   = 1'b0;
        cur_tag  = "R1 reset";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and default fan-out
        idle("R1 reset");
        for (int i = 0; i < 16; i++)
            step(1'b1, N'(i), 1'b0, '0, '0, "R1 default map");
        idle("R1");

        // R2: copy routes
        for (int j = 0; j < M; j++) cfg_write(j, 0, $urandom_range(0, N-1), 0, 0, "R2");
        slices(16, "R2 copy");
        idle("R2");

        // R3: inverted routes
        for (int j = 0; j < M; j++) cfg_write(j, 1, $urandom_range(0, N-1), 0, 0, "R3");
        slices(16, "R3 invert");
        idle("R3");

        // R4: every pair function
        for (int f = 0; f < 6; f++) begin
            for (int j = 0; j < M; j++)
                cfg_write(j, 2, $urandom_range(0, N-1), $urandom_range(0, N-1), f, "R4");
            for (int i = 0; i < 16; i++)
                step(1'b1, N'(i), 1'b0, '0, '0, "R4 pair fn");
            idle("R4");
        end

        // R5 / R6: gapped valid pattern
        for (int i = 0; i < 60; i++)
            step(1'($urandom_range(0, 1)), N'($urandom), 1'b0, '0, '0, "R5 R6 gaps");
        idle("R5");

        // R7: writes during a burst are refused
        for (int j = 0; j < M; j++) cfg_write(j, 0, j % N, 0, 0, "R7 setup");
        slices(2, "R7");
        for (int j = 0; j < M; j++)
            step(1'b1, N'($urandom), 1'b1, AW'(j), enc(1, j % N, 0, 0), "R7 busy write");
        slices(8, "R7 after");
        idle("R7");
        slices(4, "R7 still copy");
        idle("R7");

        // R8: out-of-range addresses
        cfg_write(6, 3, 0, 0, 0, "R8");
        cfg_write(7, 3, 0, 0, 0, "R8");
        slices(8, "R8 unchanged");
        idle("R8");

        // R9: zero mode and reserved function codes
        cfg_write(0, 3, 1, 2, 0, "R9");
        cfg_write(1, 2, 0, 1, 6, "R9");
        cfg_write(2, 2, 2, 3, 7, "R9");
        for (int i = 0; i < 16; i++)
            step(1'b1, N'(i), 1'b0, '0, '0, "R9 zero");
        idle("R9");

        // R10: write together with the first valid slice
        for (int k = 0; k < 6; k++) begin
            step(1'b1, N'($urandom), 1'b1, AW'(k), enc(1, k % N, 0, 0), "R10 same edge");
            slices(3, "R10 new route");
            idle("R10");
        end

        // Mixed random traffic
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 3) != 0), N'($urandom),
                 1'($urandom_range(0, 4) == 0), AW'($urandom), CW'($urandom),
                 "R2 R3 R4 mix");
        idle("mix");
        idle("mix");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule